// File: doc/BRIEF.md
# Multi-Port Packet Bus Receiver

This block is the receiving end of a 32-bit packet bus that several ports share. The sending device announces which port a packet belongs to with a select cycle. It then streams data words, and a valid flag qualifies each word. Start and end strobes mark the packet boundaries. A 2-bit field gives the number of bytes in the final word. Every word also carries a parity bit and an error flag. The receiver rebuilds the packets and passes each word on through a valid/ready stream. Each output word carries its port number, start and end markers, a byte count and an error tag.

The receiver can stop the sender with an active-low read enable. The sender only reacts to this enable after a delay, so words already in flight keep arriving after a pause is requested. The receiver therefore requests a pause while there is still room for two more words. A one-word staging register sits in front of a small queue. It allows a packet that the next start strobe cuts short to be closed with an error-tagged final word.

Top module: `pktbus_rx`

## Requirements
- R1: A cycle with `rx_sel` high loads `rx_dat[7:0]` as the current port. Every word accepted afterwards carries that value on `out_port` until the next select cycle, and the select cycle itself delivers no word.
- R2: A packet begins at an accepted word with `rx_sop` high and ends at an accepted word with `rx_eop` high. Its words leave in arrival order, with `out_sop` set only on the first word and `out_eop` only on the last.
- R3: A word is accepted only on a cycle with `rx_val` high and `rx_sel` low. Data and strobes on any other cycle have no effect on the output stream.
- R4: `rx_rd_n` is active low. It is high during reset and goes low after reset while there is room.
- R5: `rx_rd_n` goes high once the words held (queue plus staging register) leave `IN_FLIGHT` (2) or fewer of `DEPTH` entries free. A sender that keeps sending for two cycles after the pause request loses no word. With `out_ready` held low, such a sender gets exactly `DEPTH` words accepted before it stalls.
- R6: On an end-of-packet word, `out_bytes` is 4 minus `rx_mod` (00→4, 01→3, 10→2, 11→1). Every other word reports 4, whatever value `rx_mod` carries.
- R7: Each accepted word must have an odd number of ones across `rx_dat` and `rx_par`. A word that breaks this rule, or that arrives with `rx_err` high, sets `out_err` on the end-of-packet word of its packet. `out_err` is 0 on every other word, and the next packet starts clean.
- R8: An accepted start word that arrives while a packet is still open closes the open packet. The last word already accepted for it leaves with `out_eop`=1, `out_err`=1 and `out_bytes`=4, and the new packet proceeds normally.
- R9: While `out_valid` is high and `out_ready` is low, the output word and `out_valid` stay unchanged.
- R10: During reset `out_valid` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Receive clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rx_sel | input | 1 | Port-address cycle marker |
| rx_sop | input | 1 | First word of a packet |
| rx_eop | input | 1 | Last word of a packet |
| rx_val | input | 1 | Data word valid |
| rx_mod | input | 2 | Unused-byte count of the last word |
| rx_err | input | 1 | Sender-flagged word error |
| rx_dat | input | 32 | Data word, or port address on select cycles |
| rx_par | input | 1 | Odd parity bit over `rx_dat` |
| rx_rd_n | output | 1 | Active-low read enable to the sender |
| out_valid | output | 1 | Output word available |
| out_ready | input | 1 | Consumer accepts the output word |
| out_data | output | 32 | Output data word |
| out_port | output | 8 | Port the word belongs to |
| out_sop | output | 1 | First word of a packet |
| out_eop | output | 1 | Last word of a packet |
| out_bytes | output | 3 | Valid bytes in the word (1 to 4) |
| out_err | output | 1 | Packet error tag, on the last word only |

## Verification
The bench builds the receiver with `DEPTH` = 8 rather than the default 16, with the in-flight allowance left at 2. This lets a single twelve-word packet, sent while the consumer is stalled, fill the queue to its edge. The bench's sender model keeps driving for exactly two cycles after each pause request. This makes the count of accepted words at the stall point an exact figure (eight). Any pause raised one word late then shows up as an overflow, and any pause raised one word early shows up as a short count.

// File: rtl/pktbus_pkg.sv
package pktbus_pkg;

    localparam int DATA_W  = 32;
    localparam int PORT_W  = 8;
    localparam int BYTES_W = 3;

    typedef struct packed {
        logic [DATA_W-1:0]  data;
        logic [PORT_W-1:0]  port;
        logic               sop;
        logic               eop;
        logic [BYTES_W-1:0] bytes;
        logic               err;
    } pkt_word_t;

    // Unused-byte field to valid-byte count: 0 -> 4 ... 3 -> 1.
    function automatic logic [BYTES_W-1:0] mod_to_bytes(input logic [1:0] m);
        return BYTES_W'(3'd4 - {1'b0, m});
    endfunction

endpackage

// File: rtl/pktbus_frame.sv
module pktbus_frame
    import pktbus_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                sel,
    input  logic                sop,
    input  logic                eop,
    input  logic                val,
    input  logic [1:0]          mod,
    input  logic                err_in,
    input  logic [DATA_W-1:0]   dat,
    input  logic                par,
    output logic [1:0]          wr_n,
    output pkt_word_t           wr_a,
    output pkt_word_t           wr_b,
    output logic                stg_nxt
);

    typedef struct packed {
        logic [PORT_W-1:0] port;
        logic              stg_v;
        pkt_word_t         stg;
        logic              acc;
    } frame_t;

    frame_t s_d, s_q;

    always_comb begin
        logic      take;
        logic      bad;
        logic      acc_base;
        pkt_word_t cur;
        pkt_word_t rel;

        s_d  = s_q;
        wr_n = 2'd0;
        wr_a = '0;
        wr_b = '0;

        take = val & ~sel;
        bad  = ~(^{dat, par}) | err_in;

        cur.data  = dat;
        cur.port  = s_q.port;
        cur.sop   = sop;
        cur.eop   = eop;
        cur.bytes = eop ? mod_to_bytes(mod) : BYTES_W'(4);
        acc_base  = sop ? 1'b0 : s_q.acc;
        cur.err   = eop & (acc_base | bad);

        // Held word leaves; a fresh start cuts the old packet short.
        rel = s_q.stg;
        if (sop) begin
            rel.eop = 1'b1;
            rel.err = 1'b1;
        end

        if (sel) begin
            s_d.port = dat[PORT_W-1:0];
        end

        if (take) begin
            if (s_q.stg_v) begin
                wr_a = rel;
                wr_n = 2'd1;
            end
            if (eop) begin
                if (s_q.stg_v) begin
                    wr_b = cur;
                end else begin
                    wr_a = cur;
                end
                wr_n      = wr_n + 2'd1;
                s_d.stg_v = 1'b0;
                s_d.acc   = 1'b0;
            end else begin
                s_d.stg   = cur;
                s_d.stg_v = 1'b1;
                s_d.acc   = acc_base | bad;
            end
        end

        stg_nxt = s_d.stg_v;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    // R2: a finished word never waits in the staging register
    a_r2_stage_open: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.stg_v |-> !s_q.stg.eop);

    // R7: error tag rides only on a closing word
    a_r7_err_on_last: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_n != 2'd0) && !wr_a.eop |-> !wr_a.err);

endmodule

// File: rtl/pktbus_fifo.sv
module pktbus_fifo
    import pktbus_pkg::*;
#(
    parameter int DEPTH = 16
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic [1:0]                  wr_n,
    input  pkt_word_t                   wr_a,
    input  pkt_word_t                   wr_b,
    input  logic                        rdy,
    output logic                        vld,
    output pkt_word_t                   rd_word,
    output logic [$clog2(DEPTH+1)-1:0]  cnt_nxt
);

    localparam int AW = $clog2(DEPTH);
    localparam int CW = $clog2(DEPTH+1);

    typedef struct packed {
        pkt_word_t [DEPTH-1:0] mem;
        logic [AW-1:0]         wp;
        logic [AW-1:0]         rp;
        logic [CW-1:0]         cnt;
    } fifo_t;

    fifo_t s_d, s_q;

    function automatic logic [AW-1:0] inc(input logic [AW-1:0] p);
        return (p == AW'(DEPTH-1)) ? '0 : p + 1'b1;
    endfunction

    logic pop;

    always_comb begin
        logic [AW-1:0] wp1;
        s_d = s_q;
        wp1 = inc(s_q.wp);
        pop = (s_q.cnt != '0) & rdy;

        if (wr_n != 2'd0) begin
            s_d.mem[s_q.wp] = wr_a;
        end
        if (wr_n == 2'd2) begin
            s_d.mem[wp1] = wr_b;
        end
        case (wr_n)
            2'd1:    s_d.wp = wp1;
            2'd2:    s_d.wp = inc(wp1);
            default: s_d.wp = s_q.wp;
        endcase
        if (pop) begin
            s_d.rp = inc(s_q.rp);
        end
        s_d.cnt = s_q.cnt + CW'(wr_n) - CW'(pop);
        cnt_nxt = s_d.cnt;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign vld     = (s_q.cnt != '0);
    assign rd_word = s_q.mem[s_q.rp];

    // R5: in-flight words always find a free entry
    a_r5_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
        ({1'b0, s_q.cnt} + (CW+1)'(wr_n)) <= ((CW+1)'(DEPTH) + (CW+1)'(pop)));

    // R9: a stalled output word holds still
    a_r9_hold: assert property (@(posedge clk) disable iff (!rst_n)
        vld && !rdy |=> vld && $stable(rd_word));

endmodule

// File: rtl/pktbus_pace.sv
module pktbus_pace #(
    parameter int DEPTH     = 16,
    parameter int IN_FLIGHT = 2
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [$clog2(DEPTH+1)-1:0] cnt_nxt,
    input  logic                       stg_nxt,
    output logic                       rd_n
);

    localparam int CW = $clog2(DEPTH+1);
    localparam int HW = CW + 1;
    localparam logic [HW-1:0] LIM = HW'(DEPTH - IN_FLIGHT);

    typedef struct packed {
        logic          rd_n;
        logic [HW-1:0] held;
    } pace_t;

    pace_t s_d, s_q;

    always_comb begin
        s_d.held = {1'b0, cnt_nxt} + HW'(stg_nxt);
        s_d.rd_n = (s_d.held >= LIM);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q.rd_n <= 1'b1;
            s_q.held <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign rd_n = s_q.rd_n;

    // R5: storage plus staging never exceeds the queue depth
    a_r5_held_cap: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.held <= HW'(DEPTH));

endmodule

// File: rtl/pktbus_rx.sv
module pktbus_rx
    import pktbus_pkg::*;
#(
    parameter int DEPTH     = 16,
    parameter int IN_FLIGHT = 2
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        rx_sel,
    input  logic        rx_sop,
    input  logic        rx_eop,
    input  logic        rx_val,
    input  logic [1:0]  rx_mod,
    input  logic        rx_err,
    input  logic [31:0] rx_dat,
    input  logic        rx_par,
    output logic        rx_rd_n,
    output logic        out_valid,
    input  logic        out_ready,
    output logic [31:0] out_data,
    output logic [7:0]  out_port,
    output logic        out_sop,
    output logic        out_eop,
    output logic [2:0]  out_bytes,
    output logic        out_err
);

    localparam int CW = $clog2(DEPTH+1);

    logic [1:0]    wr_n;
    pkt_word_t     wr_a, wr_b, head;
    logic          stg_nxt;
    logic [CW-1:0] cnt_nxt;

    pktbus_frame u_frame (
        .clk     (clk),
        .rst_n   (rst_n),
        .sel     (rx_sel),
        .sop     (rx_sop),
        .eop     (rx_eop),
        .val     (rx_val),
        .mod     (rx_mod),
        .err_in  (rx_err),
        .dat     (rx_dat),
        .par     (rx_par),
        .wr_n    (wr_n),
        .wr_a    (wr_a),
        .wr_b    (wr_b),
        .stg_nxt (stg_nxt)
    );

    pktbus_fifo #(.DEPTH(DEPTH)) u_fifo (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_n    (wr_n),
        .wr_a    (wr_a),
        .wr_b    (wr_b),
        .rdy     (out_ready),
        .vld     (out_valid),
        .rd_word (head),
        .cnt_nxt (cnt_nxt)
    );

    pktbus_pace #(.DEPTH(DEPTH), .IN_FLIGHT(IN_FLIGHT)) u_pace (
        .clk     (clk),
        .rst_n   (rst_n),
        .cnt_nxt (cnt_nxt),
        .stg_nxt (stg_nxt),
        .rd_n    (rx_rd_n)
    );

    assign out_data  = head.data;
    assign out_port  = head.port;
    assign out_sop   = head.sop;
    assign out_eop   = head.eop;
    assign out_bytes = head.bytes;
    assign out_err   = head.err;

    // R6: words before the last are always full
    a_r6_full_mid: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && !out_eop |-> out_bytes == 3'd4);

    // R6: byte count of a last word is within 1..4
    a_r6_range: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && out_eop |-> (out_bytes != 3'd0) && (out_bytes <= 3'd4));

    // R7: the error tag appears only with end of packet
    a_r7_err_eop: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && out_err |-> out_eop);

endmodule

// File: tb/pktbus_rx_bench.sv
module pktbus_rx_bench;
    import pktbus_pkg::*;

    localparam int CLK_PERIOD = 10;
    localparam int DEPTH      = 8;

    logic        clk, rst_n;
    logic        rx_sel, rx_sop, rx_eop, rx_val, rx_err, rx_par;
    logic [1:0]  rx_mod;
    logic [31:0] rx_dat;
    logic        rx_rd_n, out_valid, out_ready;
    logic [31:0] out_data;
    logic [7:0]  out_port;
    logic        out_sop, out_eop, out_err;
    logic [2:0]  out_bytes;

    pktbus_rx #(.DEPTH(DEPTH), .IN_FLIGHT(2)) u_pktbus_rx (
        .clk(clk), .rst_n(rst_n), .rx_sel(rx_sel), .rx_sop(rx_sop),
        .rx_eop(rx_eop), .rx_val(rx_val), .rx_mod(rx_mod), .rx_err(rx_err),
        .rx_dat(rx_dat), .rx_par(rx_par), .rx_rd_n(rx_rd_n),
        .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
        .out_port(out_port), .out_sop(out_sop), .out_eop(out_eop),
        .out_bytes(out_bytes), .out_err(out_err)
    );

    int n_chk = 0;
    int n_bad = 0;
    int sent  = 0;
    logic [2:0] hist = 3'b111;
    pkt_word_t got_q[$];
    pkt_word_t exp_q[$];

    initial clk = 1'b0;
    always #(CLK_PERIOD/2) clk = ~clk;

    // Read-enable history: hist[2] is the value two edges back.
    always @(posedge clk) begin
        #1;
        hist = {hist[1:0], rx_rd_n};
    end

    // Output collector, sampled a quarter period before the edge.
    always @(negedge clk) begin
        #(CLK_PERIOD/4);
        if (rst_n && out_valid && out_ready) begin
            got_q.push_back('{data: out_data, port: out_port, sop: out_sop,
                              eop: out_eop, bytes: out_bytes, err: out_err});
        end
    end

    task automatic check_val(string req, string what, logic [63:0] act, logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic drive_idle();
        rx_sel = 1'b0; rx_val = 1'b0; rx_sop = 1'b1; rx_eop = 1'b1;
        rx_mod = 2'b10; rx_err = 1'b1; rx_dat = 32'hBAD0_F00D; rx_par = 1'b0;
    endtask

    task automatic sel_port(input logic [7:0] p);
        @(negedge clk);
        drive_idle();
        rx_sel = 1'b1; rx_val = 1'b1; rx_dat = {24'hFFFFFF, p};
    endtask

    task automatic send_word(input logic [31:0] d, input logic s, input logic e,
                             input logic [1:0] m, input logic er, input logic badp);
        @(negedge clk);
        while (hist[2]) begin
            drive_idle();
            @(negedge clk);
        end
        rx_sel = 1'b0; rx_val = 1'b1; rx_sop = s; rx_eop = e; rx_mod = m;
        rx_err = er; rx_dat = d; rx_par = badp ? (^d) : ~(^d);
        sent++;
    endtask

    task automatic gap(input int n);
        repeat (n) begin
            @(negedge clk);
            drive_idle();
        end
    endtask

    task automatic expect_word(input logic [31:0] d, input logic [7:0] p, input logic s,
                               input logic e, input logic [2:0] b, input logic er);
        exp_q.push_back('{data: d, port: p, sop: s, eop: e, bytes: b, err: er});
    endtask

    task automatic drain_compare(string req);
        gap(1);
        out_ready = 1'b1;
        repeat (3*DEPTH + 10) @(negedge clk);
        check_val(req, "word count", 64'(got_q.size()), 64'(exp_q.size()));
        for (int i = 0; i < exp_q.size(); i++) begin
            if (i < got_q.size()) begin
                check_val(req, $sformatf("word %0d", i), 64'(got_q[i]), 64'(exp_q[i]));
            end
        end
        got_q.delete();
        exp_q.delete();
    endtask

    // R10, R4: reset values and release of the read enable
    task automatic t_reset();
        rst_n = 1'b0; out_ready = 1'b1; drive_idle();
        repeat (4) @(negedge clk);
        check_val("R10", "out_valid in reset", 64'(out_valid), 64'd0);
        check_val("R4", "rd_n in reset", 64'(rx_rd_n), 64'd1);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        check_val("R4", "rd_n after reset", 64'(rx_rd_n), 64'd0);
        check_val("R10", "out_valid idle", 64'(out_valid), 64'd0);
    endtask

    // R1, R2: framing with a port switch between packets
    task automatic t_basic();
        sel_port(8'h23);
        for (int i = 0; i < 5; i++) begin
            send_word(32'h2300_0000 + i, i == 0, i == 4, 2'b01, 1'b0, 1'b0);
            expect_word(32'h2300_0000 + i, 8'h23, i == 0, i == 4, (i == 4) ? 3'd3 : 3'd4, 1'b0);
        end
        sel_port(8'h05);
        for (int i = 0; i < 2; i++) begin
            send_word(32'h0500_0000 + i, i == 0, i == 1, 2'b00, 1'b0, 1'b0);
            expect_word(32'h0500_0000 + i, 8'h05, i == 0, i == 1, 3'd4, 1'b0);
        end
        drain_compare("R1");
    endtask

    // R3: cycles without valid carry junk strobes that must vanish
    task automatic t_gaps();
        sel_port(8'h7A);
        for (int i = 0; i < 4; i++) begin
            send_word(32'h7A00_1000 + i, i == 0, i == 3, 2'b10, 1'b0, 1'b0);
            expect_word(32'h7A00_1000 + i, 8'h7A, i == 0, i == 3, (i == 3) ? 3'd2 : 3'd4, 1'b0);
            gap(i + 1);
        end
        drain_compare("R3");
    endtask

    // R6: every modulo value, plus ignored modulo on middle words
    task automatic t_mod();
        sel_port(8'h31);
        for (int m = 0; m < 4; m++) begin
            send_word(32'h3100_0000 + m, 1'b1, 1'b1, 2'(m), 1'b0, 1'b0);
            expect_word(32'h3100_0000 + m, 8'h31, 1'b1, 1'b1, 3'(4 - m), 1'b0);
        end
        for (int i = 0; i < 3; i++) begin
            send_word(32'h3101_0000 + i, i == 0, i == 2, (i == 2) ? 2'b00 : 2'b11, 1'b0, 1'b0);
            expect_word(32'h3101_0000 + i, 8'h31, i == 0, i == 2, 3'd4, 1'b0);
        end
        drain_compare("R6");
    endtask

    // R7: parity error, clean follow-up, error input on last word
    task automatic t_parity();
        sel_port(8'h42);
        for (int i = 0; i < 4; i++) begin
            send_word(32'h4200_0000 + i, i == 0, i == 3, 2'b00, 1'b0, i == 1);
            expect_word(32'h4200_0000 + i, 8'h42, i == 0, i == 3, 3'd4, i == 3);
        end
        for (int i = 0; i < 2; i++) begin
            send_word(32'h4201_0000 + i, i == 0, i == 1, 2'b00, 1'b0, 1'b0);
            expect_word(32'h4201_0000 + i, 8'h42, i == 0, i == 1, 3'd4, 1'b0);
        end
        for (int i = 0; i < 2; i++) begin
            send_word(32'h4202_0000 + i, i == 0, i == 1, 2'b01, i == 1, 1'b0);
            expect_word(32'h4202_0000 + i, 8'h42, i == 0, i == 1, (i == 1) ? 3'd3 : 3'd4, i == 1);
        end
        drain_compare("R7");
    endtask

    // R8: a new start closes the open packet with an error
    task automatic t_early();
        sel_port(8'h11);
        for (int i = 0; i < 3; i++) begin
            send_word(32'h1100_0000 + i, i == 0, 1'b0, 2'b11, 1'b0, 1'b0);
            expect_word(32'h1100_0000 + i, 8'h11, i == 0, i == 2, 3'd4, i == 2);
        end
        sel_port(8'h44);
        for (int i = 0; i < 2; i++) begin
            send_word(32'h4400_0000 + i, i == 0, i == 1, 2'b10, 1'b0, 1'b0);
            expect_word(32'h4400_0000 + i, 8'h44, i == 0, i == 1, (i == 1) ? 3'd2 : 3'd4, 1'b0);
        end
        drain_compare("R8");
    endtask

    // R5, R9: stalled consumer, exact fill level, held output word
    task automatic t_backpressure();
        logic [31:0] held;
        @(negedge clk);
        out_ready = 1'b0;
        sent = 0;
        sel_port(8'h5C);
        fork
            begin
                for (int i = 0; i < 12; i++) begin
                    send_word(32'h5C00_0000 + i, i == 0, i == 11, 2'b00, 1'b0, 1'b0);
                    expect_word(32'h5C00_0000 + i, 8'h5C, i == 0, i == 11, 3'd4, 1'b0);
                end
            end
            begin
                repeat (30) @(negedge clk);
                check_val("R5", "words accepted at stall", 64'(sent), 64'(DEPTH));
                check_val("R5", "rd_n at stall", 64'(rx_rd_n), 64'd1);
                check_val("R9", "out_valid at stall", 64'(out_valid), 64'd1);
                held = out_data;
                repeat (3) @(negedge clk);
                check_val("R9", "stalled data", 64'(out_data), 64'(held));
                out_ready = 1'b1;
            end
        join
        drain_compare("R5");
    endtask

    initial begin
        fork
            begin
                repeat (100000) @(posedge clk);
                n_bad++;
                $display("FAIL watchdog: actual timeout expected completion");
                $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
                $finish;
            end
        join_none
        t_reset();
        t_basic();
        t_gaps();
        t_mod();
        t_parity();
        t_early();
        t_backpressure();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule